// File: doc/BRIEF.md
# Serial EEPROM Pin Port

This block gives the CPU direct, bit-level control over the three input pins of a three-wire serial EEPROM (chip select, shift clock and serial data in). It also lets the CPU sample the EEPROM's serial data-out line. Software toggles the pins one write at a time and so runs the whole EEPROM protocol itself. The block only latches pin levels and reflects the returned bit.

A separate mode register supplies a swap-mode level. While that level is high, the two low data bits of a write are exchanged before they are latched. The two latched low bits are exchanged again on their way to the clock and data pins. The two exchanges cancel, so a write gives the same pin levels in either mode. If the mode level changes and no new write follows, the latched bits keep their values. The clock and data pins then trade levels until the next write. All pins come from flip-flops, so they change only on a clock edge.

Top module: `mw_pin_port`

## Requirements
- R1: A write whose address has upper byte 0x52 (low byte ignored), made while swap mode is 0, sets the pins after that cycle's clock edge: data bit 2 to CS, bit 1 to CLK, bit 0 to DI.
- R2: A write made while swap mode is 1 gives the same pin levels as R1: bit 2 to CS, bit 1 to CLK, bit 0 to DI.
- R3: When swap mode changes and no write occurs in that cycle, CLK and DI exchange levels after the next clock edge. CS keeps its level. Returning the mode to its earlier value restores the original levels.
- R4: A write whose address upper byte is not 0x52 leaves all three pins unchanged.
- R5: A read whose address upper byte is 0x55 returns the EEPROM data-out level, not inverted, on read data bit 2. All other read data bits are 0.
- R6: Read data is 0 whenever no read is in progress or the address upper byte is not 0x55.
- R7: While reset is low, CS, CLK and DI are all 0.
- R8: When a write and a change of swap mode fall in the same cycle, the mode level present in that cycle governs both exchanges. The pins then equal the written bits as in R1.
- R9: With no write and a steady swap mode, the pins hold their levels. Rewriting identical values also leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read in progress |
| swap_mode | input | 1 | Bit-pair swap mode from the mode register |
| eep_do | input | 1 | EEPROM serial data-out level |
| eep_cs | output | 1 | EEPROM chip select |
| eep_clk | output | 1 | EEPROM shift clock |
| eep_di | output | 1 | EEPROM serial data in |
| cpu_rdata | output | 8 | CPU read data |

## Verification
A pin write and a change of swap mode can fall in the same cycle. If the two exchanges used different mode levels, CLK and DI would come out reversed. The bench provokes this by raising swap mode in the very cycle of a write. It then expects the written bits on the pins after the edge, with no exchange. It also checks the opposite case: a mode change with no write must exchange CLK and DI while CS holds its level.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int PIN_W = 3;

    typedef struct packed {
        logic [PIN_W-1:0] lat;
        logic             cs;
        logic             sck;
        logic             sdi;
    } mw_state_t;

endpackage

// File: rtl/mw_page_match.sv
module mw_page_match #(
    parameter int             ADDR_W = 16,
    parameter int             PAGE_W = 8,
    parameter logic [PAGE_W-1:0] PAGE = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    output logic              hit
);
    localparam int LOW_W = ADDR_W - PAGE_W;

    always_comb begin
        hit = en && (addr[ADDR_W-1:LOW_W] == PAGE);
    end
endmodule

// File: rtl/mw_pair_swap.sv
module mw_pair_swap #(
    parameter int W = 3
) (
    input  logic [W-1:0] din,
    input  logic         swap,
    output logic [W-1:0] dout
);
    generate
        if (W > 2) begin : g_upper
            assign dout[W-1:2] = din[W-1:2];
        end
    endgenerate

    assign dout[1] = swap ? din[0] : din[1];
    assign dout[0] = swap ? din[1] : din[0];
endmodule

// File: rtl/mw_rd_mux.sv
module mw_rd_mux #(
    parameter int DATA_W = 8,
    parameter int DO_BIT = 2
) (
    input  logic              hit,
    input  logic              sdo,
    output logic [DATA_W-1:0] rdata
);
    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            if (i == DO_BIT) begin : g_do
                assign rdata[i] = hit & sdo;
            end else begin : g_zero
                assign rdata[i] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/mw_pin_port.sv
module mw_pin_port
    import mw_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter int                DATA_W  = 8,
    parameter int                PAGE_W  = 8,
    parameter logic [PAGE_W-1:0] WR_PAGE = 8'h52,
    parameter logic [PAGE_W-1:0] RD_PAGE = 8'h55,
    parameter int                DO_BIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic              swap_mode,
    input  logic              eep_do,
    output logic              eep_cs,
    output logic              eep_clk,
    output logic              eep_di,
    output logic [DATA_W-1:0] cpu_rdata
);
    localparam int CS_IDX  = PIN_W - 1;
    localparam int SCK_IDX = 1;
    localparam int SDI_IDX = 0;

    logic             wr_hit;
    logic             rd_hit;
    logic [PIN_W-1:0] wr_bits;
    logic [PIN_W-1:0] lat_next;
    logic [PIN_W-1:0] pin_next;
    mw_state_t        st_d;
    mw_state_t        st_q;

    mw_page_match #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PAGE(WR_PAGE)) u_wr_dec (
        .addr (cpu_addr),
        .en   (cpu_wr),
        .hit  (wr_hit)
    );

    mw_page_match #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PAGE(RD_PAGE)) u_rd_dec (
        .addr (cpu_addr),
        .en   (cpu_rd),
        .hit  (rd_hit)
    );

    // Exchange on the way in
    mw_pair_swap #(.W(PIN_W)) u_in_swap (
        .din  (cpu_wdata[PIN_W-1:0]),
        .swap (swap_mode),
        .dout (wr_bits)
    );

    assign lat_next = wr_hit ? wr_bits : st_q.lat;

    // Exchange on the way out, using the same mode level
    mw_pair_swap #(.W(PIN_W)) u_out_swap (
        .din  (lat_next),
        .swap (swap_mode),
        .dout (pin_next)
    );

    mw_rd_mux #(.DATA_W(DATA_W), .DO_BIT(DO_BIT)) u_rd_mux (
        .hit   (rd_hit),
        .sdo   (eep_do),
        .rdata (cpu_rdata)
    );

    always_comb begin
        st_d     = st_q;
        st_d.lat = lat_next;
        st_d.cs  = pin_next[CS_IDX];
        st_d.sck = pin_next[SCK_IDX];
        st_d.sdi = pin_next[SDI_IDX];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eep_cs  = st_q.cs;
    assign eep_clk = st_q.sck;
    assign eep_di  = st_q.sdi;
endmodule

// File: rtl/mw_pin_port_chk.sv
module mw_pin_port_chk #(
    parameter int                ADDR_W  = 16,
    parameter int                DATA_W  = 8,
    parameter int                PAGE_W  = 8,
    parameter logic [PAGE_W-1:0] WR_PAGE = 8'h52,
    parameter logic [PAGE_W-1:0] RD_PAGE = 8'h55,
    parameter int                DO_BIT  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic              swap_mode,
    input logic              eep_do,
    input logic              eep_cs,
    input logic              eep_clk,
    input logic              eep_di,
    input logic [DATA_W-1:0] cpu_rdata
);
    localparam int LOW_W = ADDR_W - PAGE_W;

    logic wr_sel;
    logic rd_sel;
    assign wr_sel = cpu_wr && (cpu_addr[ADDR_W-1:LOW_W] == WR_PAGE);
    assign rd_sel = cpu_rd && (cpu_addr[ADDR_W-1:LOW_W] == RD_PAGE);

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_PINS_LOW: assert ({eep_cs, eep_clk, eep_di} == 3'b000); // R7
        end
    end

    AST_WRITE_SETS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> ({eep_cs, eep_clk, eep_di} == $past(cpu_wdata[2:0]))); // R2

    AST_MODE_FLIP_SWAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_sel && (swap_mode != $past(swap_mode)))
        |=> (eep_clk == $past(eep_di) && eep_di == $past(eep_clk))); // R3

    AST_CS_IGNORES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(eep_cs)); // R4

    AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_sel && (swap_mode == $past(swap_mode))) |=> $stable({eep_cs, eep_clk, eep_di})); // R9

    AST_READ_DO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |-> (cpu_rdata == (DATA_W'(eep_do) << DO_BIT))); // R5

    AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_sel |-> (cpu_rdata == '0)); // R6
endmodule

bind mw_pin_port mw_pin_port_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
    .WR_PAGE(WR_PAGE), .RD_PAGE(RD_PAGE), .DO_BIT(DO_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .swap_mode (swap_mode),
    .eep_do    (eep_do),
    .eep_cs    (eep_cs),
    .eep_clk   (eep_clk),
    .eep_di    (eep_di),
    .cpu_rdata (cpu_rdata)
);

// File: tb/mw_pin_port_tb.sv
module mw_pin_port_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic        swap_mode = 1'b0;
    logic        eep_do = 1'b0;
    logic        eep_cs, eep_clk, eep_di;
    logic [7:0]  cpu_rdata;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0] pins;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    // bench model: bits as written and the mode level at that write
    logic [2:0] m_bits = 3'b000;
    logic       m_mode = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_pin_port u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .swap_mode(swap_mode), .eep_do(eep_do),
        .eep_cs(eep_cs), .eep_clk(eep_clk), .eep_di(eep_di), .cpu_rdata(cpu_rdata)
    );

    function automatic logic [2:0] model_pins(input logic cur_mode);
        if (cur_mode == m_mode) return m_bits;
        return {m_bits[2], m_bits[0], m_bits[1]};
    endfunction

    // Monitor: compare pins one half period after each edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_run++;
                if ({eep_cs, eep_clk, eep_di} !== e.pins) begin
                    n_fail++;
                    $display("FAIL %s pins act=%b exp=%b", e.req, {eep_cs, eep_clk, eep_di}, e.pins);
                end
            end
        end
    end

    // Driver: one cycle of stimulus, then queue the expected pins
    task automatic step(input logic wr, input logic [15:0] addr, input logic [7:0] data,
                        input logic mode, input string req);
        @(negedge clk);
        cpu_wr = wr; cpu_addr = addr; cpu_wdata = data; swap_mode = mode; cpu_rd = 1'b0;
        @(posedge clk);
        if (wr && addr[15:8] == 8'h52) begin
            m_bits = data[2:0];
            m_mode = mode;
        end
        sb_q.push_back('{pins: model_pins(mode), req: req});
        #1;
        cpu_wr = 1'b0;
    endtask

    task automatic rd_check(input logic rd, input logic [15:0] addr, input logic dout,
                            input logic [7:0] exp, input string req);
        @(negedge clk);
        cpu_rd = rd; cpu_addr = addr; eep_do = dout; cpu_wr = 1'b0;
        #1;
        n_run++;
        if (cpu_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s rdata act=%h exp=%h", req, cpu_rdata, exp);
        end
        cpu_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_run++;
        if ({eep_cs, eep_clk, eep_di} !== 3'b000) begin
            n_fail++;
            $display("FAIL R7 reset pins act=%b exp=000", {eep_cs, eep_clk, eep_di});
        end
        rst_n = 1'b1;

        // R1: plain mode writes
        step(1, 16'h5200, 8'h05, 0, "R1");
        step(1, 16'h5200, 8'hFA, 0, "R1");
        step(1, 16'h5200, 8'h07, 0, "R1");
        // R8: write in the same cycle the mode rises
        step(1, 16'h5200, 8'h01, 1, "R8");
        // R2: writes in swap mode
        step(1, 16'h5200, 8'h06, 1, "R2");
        step(1, 16'h5200, 8'h02, 1, "R2");
        // R3: toggle mode with no write: CLK/DI trade, CS holds
        step(0, 16'h0000, 8'h00, 0, "R3");
        step(0, 16'h0000, 8'h00, 1, "R3");
        step(1, 16'h5200, 8'h05, 1, "R2");
        step(0, 16'h0000, 8'h00, 0, "R3");
        step(0, 16'h0000, 8'h00, 0, "R9");
        // R8: write coinciding with the mode falling
        step(1, 16'h5200, 8'h06, 0, "R8");
        // R4: other pages are ignored; low byte is don't-care
        step(1, 16'h5300, 8'h01, 0, "R4");
        step(1, 16'h5000, 8'h01, 0, "R4");
        step(1, 16'h52FF, 8'h01, 1, "R1");
        // R9: identical rewrite and idle cycles hold
        step(1, 16'h5200, 8'h01, 1, "R9");
        step(0, 16'h5200, 8'h07, 1, "R9");
        step(0, 16'h0000, 8'h00, 1, "R9");
        @(negedge clk);
        @(negedge clk);

        // R5 / R6: read path
        rd_check(1, 16'h5500, 1'b1, 8'h04, "R5");
        rd_check(1, 16'h5500, 1'b0, 8'h00, "R5");
        rd_check(1, 16'h55AB, 1'b1, 8'h04, "R5");
        rd_check(0, 16'h5500, 1'b1, 8'h00, "R6");
        rd_check(1, 16'h5400, 1'b1, 8'h00, "R6");
        rd_check(1, 16'h5200, 1'b1, 8'h00, "R6");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule